// File: doc/BRIEF.md
# Thermal Statistics and Pass Selector

This block is the second-pass engine of a two-pass cloud screening pipeline. It looks at one band only, the thermal band, together with the label the first pass gave each pixel. Each frame runs in two phases. In the statistics phase the block sums the zeroth through third powers of the thermal value over every pixel that the first pass called cloud. A host reads these four sums and derives the mean, the deviation and the skew of cloud temperature. From them the host sets a new thermal threshold and loads it into the block.

In the reclassify phase the block streams the pixels again at one per clock. An ambiguous pixel becomes cloud when it is colder than the threshold and clear when it is not. Every other label passes through unchanged. Two cover counters run during this phase. One counts the first-pass cloud pixels. The other counts cloud pixels in the merged output.

When the frame ends, the block compares the two cover counts against a host limit. If they diverge too far, the cloud signature is treated as corrupt and the block flags that the first-pass result must be used for every pixel.

Top module: `thermal_pass2_engine`

## Requirements
- R1: A one-cycle pulse on `start_i` clears the moment sums, both cover counters, the mask output, `done_o` and `use_pass1_o`. A pixel presented in the same cycle as the pulse is discarded, and so is a pixel still in the moment pipeline.
- R2: The class codes are 00 clear, 01 cloud, 10 ambiguous and 11 reserved. When `phase_i` is 0, each valid pixel of class 01 adds one to `cnt_o`. The sum outputs show that pixel two clock edges after it is sampled. Pixels of any other class leave the sums untouched.
- R3: For each accumulated pixel of thermal value v, `sum_o` grows by v, `sumsq_o` by v squared and `sumcube_o` by v cubed, with no truncation. This holds for every 16-bit value, including 0xFFFF.
- R4: When `phase_i` is 1, a valid pixel of class 10 comes out one cycle later on `mask_class_o`. It is 01 if its thermal value is strictly less than `thresh_i`, and 00 otherwise, including when the value equals the threshold.
- R5: When `phase_i` is 1, a valid pixel of class 00, 01 or 11 comes out one cycle later with its code unchanged and `mask_valid_o` high, whatever its thermal value.
- R6: When `phase_i` is 1, `cover1_o` counts valid input pixels of class 01 and `cover2_o` counts output pixels of class 01. Both counters update one cycle after the pixel is sampled.
- R7: A cycle with `eof_i` high produces a single-cycle `done_o` in the next cycle. In that same cycle `use_pass1_o` takes the value (|`cover2_o` − `cover1_o`| > `limit_i`), using the counts held when `eof_i` was sampled. The comparison is strict. The flag then holds until the next end-of-frame or start.
- R8: When `phase_i` is 0, `mask_valid_o` stays low and `mask_class_o` reads 00. When `phase_i` is 1, the moment sums do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start pulse; clears all state |
| phase_i | input | 1 | 0 = statistics, 1 = reclassify |
| pix_valid_i | input | 1 | Pixel qualifier |
| pix_class_i | input | 2 | First-pass class code |
| thermal_i | input | 16 | Thermal band value |
| thresh_i | input | 16 | Host-loaded thermal threshold |
| limit_i | input | 24 | Host-loaded divergence limit |
| eof_i | input | 1 | End of frame |
| cnt_o | output | 24 | Number of accumulated cloud pixels |
| sum_o | output | 40 | Sum of thermal values |
| sumsq_o | output | 56 | Sum of squared thermal values |
| sumcube_o | output | 72 | Sum of cubed thermal values |
| mask_valid_o | output | 1 | Output pixel qualifier |
| mask_class_o | output | 2 | Merged class code |
| cover1_o | output | 24 | First-pass cloud count |
| cover2_o | output | 24 | Merged cloud count |
| done_o | output | 1 | Frame decision pulse |
| use_pass1_o | output | 1 | Second-pass result rejected |

## Verification
A stale or corrupt moment register shows on the sum outputs exactly two edges after the pixel that should have changed them. It stays visible until the next start, because sums never decay. A wrong threshold compare or a wrong pass-through shows on `mask_class_o` one edge later. It also leaves a permanent offset in `cover2_o`, or in both covers. Those offsets in turn change `use_pass1_o` at the next end-of-frame. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the first cycle it is visible.

// File: rtl/tstat_pkg.sv
package tstat_pkg;

    // First-pass class codes carried on pix_class_i and mask_class_o
    typedef enum logic [1:0] {
        CLS_CLEAR = 2'b00,
        CLS_CLOUD = 2'b01,
        CLS_AMBIG = 2'b10,
        CLS_RSVD  = 2'b11
    } cls_e;

endpackage

// File: rtl/tstat_moments.sv
module tstat_moments #(
    parameter int PIX_W = 16,
    parameter int CNT_W = 24
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clr_i,
    input  logic                     take_i,
    input  logic [PIX_W-1:0]         val_i,
    output logic [CNT_W-1:0]         cnt_o,
    output logic [PIX_W+CNT_W-1:0]   sum_o,
    output logic [2*PIX_W+CNT_W-1:0] sumsq_o,
    output logic [3*PIX_W+CNT_W-1:0] sumcube_o
);

    localparam int SQ_W   = 2 * PIX_W;
    localparam int CB_W   = 3 * PIX_W;
    localparam int SUM_W  = PIX_W + CNT_W;
    localparam int SSQ_W  = SQ_W + CNT_W;
    localparam int SCB_W  = CB_W + CNT_W;

    // Stage 1 holds the value and its square; stage 2 forms the cube and adds.
    typedef struct packed {
        logic             stg_vld;
        logic [PIX_W-1:0] stg_val;
        logic [SQ_W-1:0]  stg_sq;
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] sum;
        logic [SSQ_W-1:0] ssq;
        logic [SCB_W-1:0] scb;
    } mom_t;

    mom_t             mom_d, mom_q;
    logic [SQ_W-1:0]  sq_d;
    logic [CB_W-1:0]  cube_d;

    always_comb begin
        sq_d   = SQ_W'(val_i) * SQ_W'(val_i);
        cube_d = CB_W'(mom_q.stg_sq) * CB_W'(mom_q.stg_val);
        mom_d  = mom_q;

        mom_d.stg_vld = take_i;
        mom_d.stg_val = val_i;
        mom_d.stg_sq  = sq_d;

        if (mom_q.stg_vld) begin
            mom_d.cnt = mom_q.cnt + CNT_W'(1);
            mom_d.sum = mom_q.sum + SUM_W'(mom_q.stg_val);
            mom_d.ssq = mom_q.ssq + SSQ_W'(mom_q.stg_sq);
            mom_d.scb = mom_q.scb + SCB_W'(cube_d);
        end

        if (clr_i) begin
            mom_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mom_q <= '0;
        end else begin
            mom_q <= mom_d;
        end
    end

    assign cnt_o     = mom_q.cnt;
    assign sum_o     = mom_q.sum;
    assign sumsq_o   = mom_q.ssq;
    assign sumcube_o = mom_q.scb;

    // R8: with nothing in flight and no clear, every sum keeps its value
    p_moments_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !mom_q.stg_vld) |=>
            ($stable(cnt_o) && $stable(sum_o) && $stable(sumsq_o) && $stable(sumcube_o)));

    // R1: a clear empties the counts on the following edge
    p_clear_cnt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0 && sumcube_o == '0));

endmodule

// File: rtl/tstat_reclass.sv
module tstat_reclass #(
    parameter int PIX_W = 16,
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             act_i,
    input  logic [1:0]       cls_i,
    input  logic [PIX_W-1:0] therm_i,
    input  logic [PIX_W-1:0] thresh_i,
    output logic             out_vld_o,
    output logic [1:0]       out_cls_o,
    output logic [CNT_W-1:0] cov1_o,
    output logic [CNT_W-1:0] cov2_o
);

    import tstat_pkg::*;

    typedef struct packed {
        logic             ovld;
        logic [1:0]       ocls;
        logic [CNT_W-1:0] cov1;
        logic [CNT_W-1:0] cov2;
    } rc_t;

    rc_t        rc_d, rc_q;
    logic       colder_d;
    logic [1:0] new_cls_d;

    always_comb begin
        colder_d  = (therm_i < thresh_i);
        new_cls_d = cls_i;
        if (cls_i == CLS_AMBIG) begin
            new_cls_d = colder_d ? CLS_CLOUD : CLS_CLEAR;
        end

        rc_d      = rc_q;
        rc_d.ovld = act_i;
        rc_d.ocls = act_i ? new_cls_d : CLS_CLEAR;

        if (act_i) begin
            if (cls_i == CLS_CLOUD) begin
                rc_d.cov1 = rc_q.cov1 + CNT_W'(1);
            end
            if (new_cls_d == CLS_CLOUD) begin
                rc_d.cov2 = rc_q.cov2 + CNT_W'(1);
            end
        end

        if (clr_i) begin
            rc_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rc_q <= '0;
        end else begin
            rc_q <= rc_d;
        end
    end

    assign out_vld_o = rc_q.ovld;
    assign out_cls_o = rc_q.ocls;
    assign cov1_o    = rc_q.cov1;
    assign cov2_o    = rc_q.cov2;

    // R6: the merged count never falls below the first-pass count
    p_cover_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cov2_o >= cov1_o);

    // R4: a warm-or-equal ambiguous pixel never leaves as cloud
    p_ambig_warm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i && !clr_i && cls_i == CLS_AMBIG && therm_i >= thresh_i) |=>
            (out_cls_o == CLS_CLEAR));

endmodule

// File: rtl/tstat_diverge.sv
module tstat_diverge #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             eof_i,
    input  logic [CNT_W-1:0] cov1_i,
    input  logic [CNT_W-1:0] cov2_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o,
    output logic             use_pass1_o
);

    typedef struct packed {
        logic done;
        logic use1;
    } dv_t;

    dv_t              dv_d, dv_q;
    logic [CNT_W-1:0] gap_d;

    always_comb begin
        gap_d = (cov1_i > cov2_i) ? (cov1_i - cov2_i) : (cov2_i - cov1_i);

        dv_d      = dv_q;
        dv_d.done = eof_i;
        if (eof_i) begin
            dv_d.use1 = (gap_d > limit_i);
        end

        if (clr_i) begin
            dv_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign done_o      = dv_q.done;
    assign use_pass1_o = dv_q.use1;

    // R7: the decision only moves at an end-of-frame or a clear
    p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!eof_i && !clr_i) |=> $stable(use_pass1_o));

    // R7: no done without a preceding end-of-frame
    p_done_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!eof_i || clr_i) |=> !done_o);

endmodule

// File: rtl/thermal_pass2_engine.sv
module thermal_pass2_engine #(
    parameter int PIX_W = 16,
    parameter int CNT_W = 24
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic                     phase_i,
    input  logic                     pix_valid_i,
    input  logic [1:0]               pix_class_i,
    input  logic [PIX_W-1:0]         thermal_i,
    input  logic [PIX_W-1:0]         thresh_i,
    input  logic [CNT_W-1:0]         limit_i,
    input  logic                     eof_i,
    output logic [CNT_W-1:0]         cnt_o,
    output logic [PIX_W+CNT_W-1:0]   sum_o,
    output logic [2*PIX_W+CNT_W-1:0] sumsq_o,
    output logic [3*PIX_W+CNT_W-1:0] sumcube_o,
    output logic                     mask_valid_o,
    output logic [1:0]               mask_class_o,
    output logic [CNT_W-1:0]         cover1_o,
    output logic [CNT_W-1:0]         cover2_o,
    output logic                     done_o,
    output logic                     use_pass1_o
);

    import tstat_pkg::*;

    logic take_d;
    logic act_d;

    always_comb begin
        take_d = pix_valid_i && !phase_i && (pix_class_i == CLS_CLOUD);
        act_d  = pix_valid_i && phase_i;
    end

    tstat_moments #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_moments (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (start_i),
        .take_i    (take_d),
        .val_i     (thermal_i),
        .cnt_o     (cnt_o),
        .sum_o     (sum_o),
        .sumsq_o   (sumsq_o),
        .sumcube_o (sumcube_o)
    );

    tstat_reclass #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_reclass (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (start_i),
        .act_i     (act_d),
        .cls_i     (pix_class_i),
        .therm_i   (thermal_i),
        .thresh_i  (thresh_i),
        .out_vld_o (mask_valid_o),
        .out_cls_o (mask_class_o),
        .cov1_o    (cover1_o),
        .cov2_o    (cover2_o)
    );

    tstat_diverge #(.CNT_W(CNT_W)) u_diverge (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (start_i),
        .eof_i       (eof_i),
        .cov1_i      (cover1_o),
        .cov2_i      (cover2_o),
        .limit_i     (limit_i),
        .done_o      (done_o),
        .use_pass1_o (use_pass1_o)
    );

    // R5: non-ambiguous labels leave unchanged one cycle later
    p_pass_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pix_valid_i && phase_i && !start_i && pix_class_i != CLS_AMBIG) |=>
            (mask_valid_o && mask_class_o == $past(pix_class_i)));

    // R8: the statistics phase produces no mask output
    p_no_mask_stats_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!phase_i || !pix_valid_i) |=> (!mask_valid_o && mask_class_o == CLS_CLEAR));

endmodule

// File: tb/thermal_pass2_engine_tb_top.sv
module thermal_pass2_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        phase = 1'b0;
    logic        pvld = 1'b0;
    logic [1:0]  pcls = 2'b00;
    logic [15:0] therm = 16'h0;
    logic [15:0] thresh = 16'h8000;
    logic [23:0] limit = 24'd0;
    logic        eof = 1'b0;

    logic [23:0] cnt_o;
    logic [39:0] sum_o;
    logic [55:0] sumsq_o;
    logic [71:0] sumcube_o;
    logic        mask_valid_o;
    logic [1:0]  mask_class_o;
    logic [23:0] cover1_o, cover2_o;
    logic        done_o, use_pass1_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    thermal_pass2_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .phase_i(phase),
        .pix_valid_i(pvld), .pix_class_i(pcls), .thermal_i(therm),
        .thresh_i(thresh), .limit_i(limit), .eof_i(eof),
        .cnt_o(cnt_o), .sum_o(sum_o), .sumsq_o(sumsq_o), .sumcube_o(sumcube_o),
        .mask_valid_o(mask_valid_o), .mask_class_o(mask_class_o),
        .cover1_o(cover1_o), .cover2_o(cover2_o),
        .done_o(done_o), .use_pass1_o(use_pass1_o)
    );

    // Behavioural reference model
    logic        m_pv;
    logic [15:0] m_pval;
    logic [23:0] m_cnt;
    logic [39:0] m_sum;
    logic [55:0] m_sq;
    logic [71:0] m_cube;
    logic        m_mv;
    logic [1:0]  m_mc;
    logic [23:0] m_c1, m_c2;
    logic        m_done, m_use;

    task automatic model_clear();
        m_pv = 0; m_pval = 0; m_cnt = 0; m_sum = 0; m_sq = 0; m_cube = 0;
        m_mv = 0; m_mc = 0; m_c1 = 0; m_c2 = 0; m_done = 0; m_use = 0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n || start) begin
            model_clear();
        end else begin
            logic [1:0] nc;
            if (m_pv) begin
                m_cnt  = m_cnt + 1;
                m_sum  = m_sum + 40'(m_pval);
                m_sq   = m_sq + 56'(m_pval) * 56'(m_pval);
                m_cube = m_cube + 72'(m_pval) * 72'(m_pval) * 72'(m_pval);
            end
            m_pv   = pvld && !phase && (pcls == 2'b01);
            m_pval = therm;
            m_done = eof;
            if (eof) begin
                m_use = ((m_c2 > m_c1 ? m_c2 - m_c1 : m_c1 - m_c2) > limit);
            end
            if (pvld && phase) begin
                nc = (pcls == 2'b10) ? ((therm < thresh) ? 2'b01 : 2'b00) : pcls;
                if (pcls == 2'b01) m_c1 = m_c1 + 1;
                if (nc == 2'b01)   m_c2 = m_c2 + 1;
                m_mv = 1; m_mc = nc;
            end else begin
                m_mv = 0; m_mc = 2'b00;
            end
        end
    end

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        chk("R2 count",       72'(cnt_o),        72'(m_cnt));
        chk("R3 sum",         72'(sum_o),        72'(m_sum));
        chk("R3 sum sq",      72'(sumsq_o),      72'(m_sq));
        chk("R3 sum cube",    sumcube_o,         m_cube);
        chk("R8 mask valid",  72'(mask_valid_o), 72'(m_mv));
        chk("R4/R5 class",    72'(mask_class_o), 72'(m_mc));
        chk("R6 cover1",      72'(cover1_o),     72'(m_c1));
        chk("R6 cover2",      72'(cover2_o),     72'(m_c2));
        chk("R7 done",        72'(done_o),       72'(m_done));
        chk("R7 use_pass1",   72'(use_pass1_o),  72'(m_use));
    end

    logic [31:0] lf = 32'h1ACE_B00C;
    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    task automatic px(input logic v, input logic ph, input logic [1:0] c, input logic [15:0] t);
        pvld = v; phase = ph; pcls = c; therm = t;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        pvld = 0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1; @(negedge clk); start = 0;
    endtask

    task automatic pulse_eof();
        eof = 1; @(negedge clk); eof = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [23:0] gap;
        repeat (3) @(negedge clk);
        chk("R1 reset cnt",   72'(cnt_o), 72'd0);
        chk("R1 reset cover", 72'(cover2_o), 72'd0);
        rst_n = 1;
        @(negedge clk);

        // Frame 1: statistics then reclassify
        pulse_start();
        for (int i = 0; i < 300; i++) begin
            r = rnd();
            if (i % 37 == 0) px(1, 0, 2'b01, 16'hFFFF);
            else             px(r[5] | r[6], 0, r[1:0], r[31:16]);
        end
        px(1, 0, 2'b01, 16'h0000);
        px(1, 0, 2'b10, 16'h0001);       // R2: ambiguous is not accumulated
        idle(3);
        chk("R3 max cube present", 72'(sumcube_o >= 72'h0000_FFFD_0002_FFFF), 72'd1);
        thresh = 16'h8000;
        for (int i = 0; i < 300; i++) begin
            r = rnd();
            px(r[5] | r[6], 1, r[1:0], r[31:16]);
        end
        px(1, 1, 2'b10, 16'h8000);       // R4: equal -> clear
        chk("R4 equal threshold", 72'(mask_class_o), 72'd0);
        px(1, 1, 2'b10, 16'h7FFF);       // R4: below -> cloud
        chk("R4 below threshold", 72'(mask_class_o), 72'd1);
        px(1, 1, 2'b11, 16'h0000);       // R5: reserved passes through
        chk("R5 reserved kept", 72'(mask_class_o), 72'd3);
        idle(2);
        limit = 24'd5;
        gap = m_c2 - m_c1;
        pulse_eof();
        chk("R7 done pulse", 72'(done_o), 72'd1);
        chk("R7 select", 72'(use_pass1_o), 72'(gap > 24'd5));
        @(negedge clk);
        chk("R7 done single", 72'(done_o), 72'd0);

        // Frame 2: strict limit boundary
        pulse_start();
        chk("R1 start clears select", 72'(use_pass1_o), 72'd0);
        for (int i = 0; i < 40; i++) px(1, 1, 2'b10, 16'(i * 100));
        px(1, 1, 2'b01, 16'hFFFF);
        idle(2);
        gap = m_c2 - m_c1;
        chk("R6 gap nonzero", 72'(gap > 0), 72'd1);
        limit = gap;
        pulse_eof();
        chk("R7 equal limit keeps pass two", 72'(use_pass1_o), 72'd0);
        idle(1);
        limit = gap - 24'd1;
        pulse_eof();
        chk("R7 over limit selects pass one", 72'(use_pass1_o), 72'd1);
        idle(4);
        chk("R7 select held", 72'(use_pass1_o), 72'd1);
        chk("R8 reclassify leaves sums", 72'(cnt_o), 72'd0);

        // Frame 3: start drops in-flight and same-cycle pixels
        px(1, 0, 2'b01, 16'h1234);
        start = 1;
        px(1, 0, 2'b01, 16'h4321);
        start = 0;
        idle(3);
        chk("R1 in-flight dropped", 72'(cnt_o), 72'd0);
        chk("R1 sum cleared", 72'(sum_o), 72'd0);
        px(1, 0, 2'b01, 16'd3);
        px(1, 0, 2'b00, 16'd9);
        idle(2);
        chk("R2 single cloud", 72'(cnt_o), 72'd1);
        chk("R3 cube of three", sumcube_o, 72'd27);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule